// File: doc/BRIEF.md
# Protected Default Region Descriptor Bank

This block holds the default region descriptor of a memory-protection unit: a lower bound, an upper bound, a word of access rights, and a control word whose bit 0 marks the region valid. A second register index is an alias of the rights word. Both indices read and write the same storage. Software and the debug port reach the registers over a plain register-write bus that carries the ID of the issuing master. Reads come from a separate combinational port.

Each write is filtered by a three-level master priority. The debugger may rewrite the whole descriptor. The core may change only the permission fields that belong to masters other than the debugger. Every other master is refused. As a result, the debugger can always reach the whole address space and no software can lock it out.

Any write that is trimmed or refused is dropped silently. The only sign of it is a one-cycle pulse on `wr_masked`.

Top module: `pdesc_bank`

## Requirements
- R1: After reset, the registers read as follows. Index 0 (lower bound) reads 0x0000_0000. Index 1 (upper bound) reads 0xFFFF_FFFF. Index 2 (rights) and index 4 (rights alias) read 0x0061_F7DF. Index 3 (control) reads 0x0000_0001. `wr_masked` is low.
- R2: A write from master ID 1 (debugger) updates the addressed register at indices 0 to 4 with all of its stored bits.
- R3: A write from master ID 0 (core) to index 0, 1 or 3 leaves that register unchanged.
- R4: A write from master ID 0 to index 2 or 4 updates the rights bits under mask 0xFFFF_F83F. Bits 10:9 (debugger supervisor field) and bits 8:6 (debugger user field) keep their old value.
- R5: A write from master ID 2 or 3 leaves every register unchanged.
- R6: Index 4 and index 2 share one storage word. A write accepted through either index shows up on both.
- R7: Bits 4:0 of index 0 always read as zero, and bits 4:0 of index 1 always read as ones, whatever data is written.
- R8: The read data follows `rd_idx` combinationally. Indices 5 to 7 read zero, and writes to them change no register.
- R9: `wr_masked` is high for exactly the one cycle after a write edge in which a master other than ID 1 wrote to index 0 to 4. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, applied on the rising clock edge |
| wr_idx | input | 3 | Register index of the write |
| wr_mid | input | 2 | Master ID of the write (0 core, 1 debugger, 2/3 others) |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Register index of the read |
| rd_data | output | 32 | Current value of the selected register |
| wr_masked | output | 1 | One-cycle pulse after a filtered or refused write |

## Verification
The hardest case to reach is a core write to the rights word that tries to change the debugger fields at the same time as the other fields. The merge must keep bits 10:6 from an earlier debugger write and take all the other bits from the new write. The stimulus first has the debugger plant non-reset values in bits 10:6. It then issues core writes of all-ones, all-zeros and random data through both the rights index and its alias. Random traffic then mixes all masters and indices, so that debugger, core and refused writes interleave in every order. A bench model predicts every register after each write.

// File: rtl/pdesc_pkg.sv
package pdesc_pkg;
  localparam int DW      = 32;
  localparam int IW      = 3;
  localparam int MW      = 2;
  localparam int LOWB    = 5;   // bound granule bits
  localparam int DBG_LO  = 6;   // lowest bit of debugger fields
  localparam int DBG_HI  = 10;  // highest bit of debugger fields

  localparam logic [MW-1:0] MID_CORE  = 2'd0;
  localparam logic [MW-1:0] MID_DEBUG = 2'd1;

  localparam logic [IW-1:0] IX_LOW    = 3'd0;
  localparam logic [IW-1:0] IX_HIGH   = 3'd1;
  localparam logic [IW-1:0] IX_RIGHTS = 3'd2;
  localparam logic [IW-1:0] IX_CTRL   = 3'd3;
  localparam logic [IW-1:0] IX_ALIAS  = 3'd4;

  localparam logic [DW-1:0] RST_LOW    = 32'h0000_0000;
  localparam logic [DW-1:0] RST_HIGH   = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] RST_RIGHTS = 32'h0061_F7DF;
  localparam logic [DW-1:0] RST_CTRL   = 32'h0000_0001;
endpackage

// File: rtl/pdesc_rst_sync.sv
module pdesc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdesc_wfilter.sv
module pdesc_wfilter
  import pdesc_pkg::*;
#(
  parameter int P_DW     = DW,
  parameter int P_DBG_LO = DBG_LO,
  parameter int P_DBG_HI = DBG_HI
) (
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [MW-1:0]   wr_mid,
  output logic            we_low,
  output logic            we_high,
  output logic            we_rights,
  output logic            we_ctrl,
  output logic [P_DW-1:0] rights_mask,
  output logic            masked_nxt
);
  localparam int DBG_W = P_DBG_HI - P_DBG_LO + 1;
  localparam logic [P_DW-1:0] DBG_FIELDS = ((P_DW'(1) << DBG_W) - P_DW'(1)) << P_DBG_LO;

  logic is_dbg, is_core, idx_valid, hit_rights;

  always_comb begin
    is_dbg      = (wr_mid == MID_DEBUG);
    is_core     = (wr_mid == MID_CORE);
    idx_valid   = (wr_idx <= IX_ALIAS);
    hit_rights  = (wr_idx == IX_RIGHTS) || (wr_idx == IX_ALIAS);
    we_low      = wr_en && is_dbg && (wr_idx == IX_LOW);
    we_high     = wr_en && is_dbg && (wr_idx == IX_HIGH);
    we_ctrl     = wr_en && is_dbg && (wr_idx == IX_CTRL);
    we_rights   = wr_en && (is_dbg || is_core) && hit_rights;
    rights_mask = is_dbg ? '1 : ~DBG_FIELDS;
    masked_nxt  = wr_en && !is_dbg && idx_valid;
  end
endmodule

// File: rtl/pdesc_regs.sv
module pdesc_regs
  import pdesc_pkg::*;
#(
  parameter int P_DW   = DW,
  parameter int P_LOWB = LOWB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_low,
  input  logic            we_high,
  input  logic            we_rights,
  input  logic            we_ctrl,
  input  logic [P_DW-1:0] rights_mask,
  input  logic [P_DW-1:0] wdata,
  output logic [P_DW-1:0] low_word,
  output logic [P_DW-1:0] high_word,
  output logic [P_DW-1:0] rights_word,
  output logic [P_DW-1:0] ctrl_word
);
  localparam int UB = P_DW - P_LOWB;

  logic [UB-1:0]   low_q,    low_d;
  logic [UB-1:0]   high_q,   high_d;
  logic [P_DW-1:0] rights_q, rights_d;
  logic [P_DW-1:0] ctrl_q,   ctrl_d;

  always_comb begin
    low_d    = we_low   ? wdata[P_DW-1:P_LOWB] : low_q;
    high_d   = we_high  ? wdata[P_DW-1:P_LOWB] : high_q;
    ctrl_d   = we_ctrl  ? wdata : ctrl_q;
    rights_d = we_rights ? ((rights_q & ~rights_mask) | (wdata & rights_mask)) : rights_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= RST_LOW[P_DW-1:P_LOWB];
      high_q   <= RST_HIGH[P_DW-1:P_LOWB];
      rights_q <= RST_RIGHTS;
      ctrl_q   <= RST_CTRL;
    end else begin
      if (we_low)    low_q    <= low_d;
      if (we_high)   high_q   <= high_d;
      if (we_rights) rights_q <= rights_d;
      if (we_ctrl)   ctrl_q   <= ctrl_d;
    end
  end

  assign low_word    = {low_q,  {P_LOWB{1'b0}}};
  assign high_word   = {high_q, {P_LOWB{1'b1}}};
  assign rights_word = rights_q;
  assign ctrl_word   = ctrl_q;

  AST_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_low || we_high || we_rights || we_ctrl) |=>
      $stable(low_q) && $stable(high_q) && $stable(rights_q) && $stable(ctrl_q)); // R5
endmodule

// File: rtl/pdesc_bank.sv
module pdesc_bank
  import pdesc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [MW-1:0] wr_mid,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          wr_masked
);
  logic          rst_sync_n;
  logic          we_low, we_high, we_rights, we_ctrl, masked_nxt;
  logic [DW-1:0] rights_mask;
  logic [DW-1:0] low_word, high_word, rights_word, ctrl_word;
  logic          masked_q;

  pdesc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pdesc_wfilter u_filt (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mid(wr_mid),
    .we_low(we_low), .we_high(we_high), .we_rights(we_rights), .we_ctrl(we_ctrl),
    .rights_mask(rights_mask), .masked_nxt(masked_nxt)
  );

  pdesc_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we_low(we_low), .we_high(we_high), .we_rights(we_rights), .we_ctrl(we_ctrl),
    .rights_mask(rights_mask), .wdata(wr_data),
    .low_word(low_word), .high_word(high_word),
    .rights_word(rights_word), .ctrl_word(ctrl_word)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) masked_q <= 1'b0;
    else             masked_q <= masked_nxt;
  end
  assign wr_masked = masked_q;

  always_comb begin
    unique case (rd_idx)
      IX_LOW:              rd_data = low_word;
      IX_HIGH:             rd_data = high_word;
      IX_RIGHTS, IX_ALIAS: rd_data = rights_word;
      IX_CTRL:             rd_data = ctrl_word;
      default:             rd_data = '0;
    endcase
  end

  AST_CORE_BOUNDS_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mid == MID_CORE) |=>
      $stable(low_word) && $stable(high_word) && $stable(ctrl_word)); // R3
  AST_DBG_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mid != MID_DEBUG) |=> $stable(rights_word[DBG_HI:DBG_LO])); // R4
  AST_OTHER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mid[1]) |=> $stable(low_word) && $stable(high_word) &&
      $stable(rights_word) && $stable(ctrl_word)); // R5
  AST_MASK_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_mid != MID_DEBUG && wr_idx <= IX_ALIAS) |=> wr_masked); // R9
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en || wr_mid == MID_DEBUG) |=> !wr_masked); // R9
  AST_UNUSED_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx > IX_ALIAS) |=> $stable(low_word) && $stable(high_word) &&
      $stable(rights_word) && $stable(ctrl_word)); // R8
endmodule

// File: tb/pdesc_bank_tb.sv
`timescale 1ns/100ps
module pdesc_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_mid;
  logic [31:0] wr_data;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_masked;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_low, m_high, m_rights, m_ctrl;
  logic        m_masked;

  always #4 clk = ~clk;

  pdesc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mid(wr_mid),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .wr_masked(wr_masked)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] idx);
    case (idx)
      3'd0: return m_low;
      3'd1: return m_high;
      3'd2, 3'd4: return m_rights;
      3'd3: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [1:0] mid, input logic [2:0] idx,
                                      input logic [31:0] d);
    m_masked = (mid != 2'd1) && (idx <= 3'd4);
    if (mid == 2'd1) begin
      case (idx)
        3'd0: m_low = d & 32'hFFFF_FFE0;
        3'd1: m_high = d | 32'h0000_001F;
        3'd2, 3'd4: m_rights = d;
        3'd3: m_ctrl = d;
        default: ;
      endcase
    end else if (mid == 2'd0 && (idx == 3'd2 || idx == 3'd4)) begin
      m_rights = (m_rights & 32'h0000_07C0) | (d & 32'hFFFF_F83F);
    end
  endfunction

  task automatic check_all(input string tag);
    n_run++;
    if (wr_masked !== m_masked) begin
      n_fail++;
      $display("FAIL %s/R9 wr_masked actual %0b expected %0b", tag, wr_masked, m_masked);
    end
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.2;
      n_run++;
      if (rd_data !== exp_read(3'(i))) begin
        n_fail++;
        $display("FAIL %s idx %0d actual %h expected %h", tag, i, rd_data, exp_read(3'(i)));
      end
    end
  endtask

  // called at a negedge; applies one write, checks at the next negedge
  task automatic do_write(input logic [1:0] mid, input logic [2:0] idx,
                          input logic [31:0] d, input string tag);
    wr_en = 1'b1; wr_mid = mid; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(mid, idx, d);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    m_masked = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_mid = '0; wr_data = '0; rd_idx = '0;
    m_low = 32'h0; m_high = 32'hFFFF_FFFF; m_rights = 32'h0061_F7DF;
    m_ctrl = 32'h1; m_masked = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R2 R6 R7: debugger full writes
    do_write(2'd1, 3'd0, 32'h1234_567F, "R2_R7");
    do_write(2'd1, 3'd1, 32'h8000_0000, "R2_R7");
    do_write(2'd1, 3'd2, 32'hA5A5_5A5A, "R2");
    do_write(2'd1, 3'd4, 32'h0000_07C0, "R6");
    do_write(2'd1, 3'd3, 32'h0000_0000, "R2");
    idle("R9");
    // R3: core cannot touch bounds or control
    do_write(2'd0, 3'd0, 32'hFFFF_FFFF, "R3");
    do_write(2'd0, 3'd1, 32'h0000_0000, "R3");
    do_write(2'd0, 3'd3, 32'hFFFF_FFFF, "R3");
    // R4: core partial rights through both indices
    do_write(2'd0, 3'd2, 32'h0000_0000, "R4");
    do_write(2'd0, 3'd4, 32'hFFFF_FFFF, "R4_R6");
    do_write(2'd1, 3'd2, 32'h0000_0140, "R2");
    do_write(2'd0, 3'd4, 32'hFFFF_FFFF, "R4");
    do_write(2'd0, 3'd2, 32'h1357_9BDF, "R4");
    // R5: other masters
    do_write(2'd2, 3'd2, 32'h0000_0000, "R5");
    do_write(2'd3, 3'd0, 32'hFFFF_FFE0, "R5");
    do_write(2'd2, 3'd3, 32'hDEAD_BEEF, "R5");
    // R8: unused indices
    do_write(2'd1, 3'd5, 32'hFFFF_FFFF, "R8");
    do_write(2'd0, 3'd7, 32'hFFFF_FFFF, "R8");
    idle("R9");

    for (int k = 0; k < 3000; k++) begin
      logic [1:0]  mid;
      logic [2:0]  idx;
      logic [31:0] d;
      string       tg;
      mid = 2'($urandom_range(0, 3));
      idx = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: d = 32'hFFFF_FFFF;
        1: d = 32'h0;
        default: d = $urandom;
      endcase
      tg = (idx > 3'd4) ? "R8" : (mid == 2'd1) ? "R2" : (mid == 2'd0) ? "R4" : "R5";
      if ($urandom_range(0, 4) == 0) idle("R9");
      else do_write(mid, idx, d, tg);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule